// File: doc/BRIEF.md
# Programmable Feedback Shift-Register Divider

This block is an N-stage shift register used as a counter-divider. On every clock the contents move one stage toward the output end, and a new bit enters the input stage. That new bit is not formed from fixed XOR taps. It is read from a truth table with 2^N one-bit entries, and the current register contents index the table. Software, or the surrounding logic, loads the table through a one-bit write port. The table therefore fixes the whole state graph: which loops exist, how long they are, and where strings of states join them.

A terminal-state register holds one designated state. A registered decoder raises the divided output for one cycle after each cycle in which the register holds that state. The output period therefore equals the length of the loop that contains the terminal state. A synchronous reset loads a seed value chosen at the port. The table and the terminal register keep their contents through reset, so one table can be reused from many starting points.

Top module: `fsr_divider`

## Requirements
- R1: When reset is low, each clock edge moves the state to (2*S + d) mod 2^N. Bit 0 of `state` is the input stage and bit N-1 is the final stage.
- R2: The bit d that enters is the table entry at index S, the current value of `state`.
- R3: A clock edge with `rst` high loads `seed` into `state` and drives `carry` low.
- R4: The table contents and the terminal value survive any number of reset cycles unchanged.
- R5: An edge with `tbl_we` high stores `tbl_bit` at entry `tbl_addr`. The shift on that same edge still uses the old entry, and later edges use the new one. A write never changes `state` directly.
- R6: `carry` is high in a cycle exactly when the previous cycle was out of reset and `state` equalled the terminal value. On a loop of length L that holds the terminal state, `carry` pulses once every L cycles.
- R7: An edge with `term_we` high stores `term_val` as the terminal value. The decode in that same cycle still compares against the old value.
- R8: The all-zeros state and the all-ones state are persistent when the table entry at that state equals the bit that the state already holds.
- R9: Two states that differ only in bit N-1 and have equal table entries both move to the same successor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset; loads the seed |
| seed | input | STAGES | State loaded while reset is high |
| tbl_we | input | 1 | Feedback table write strobe |
| tbl_addr | input | STAGES | Table entry to write |
| tbl_bit | input | 1 | Value written to the table |
| term_we | input | 1 | Terminal-state write strobe |
| term_val | input | STAGES | New terminal state |
| state | output | STAGES | Parallel register contents, bit 0 = input stage |
| carry | output | 1 | One-cycle pulse after the terminal state |

## Verification
The bench builds the block with STAGES = 5. This gives a 32-entry table that the bench loads in full and can follow with a software model. At that size the twisted-ring table gives a 10-state loop for the carry-period check. Pairs such as 5 and 21, which differ only in the top bit, test the merge property, and both fixed points 0 and 31 can be reached. A pseudo-random table and writes made during a run check the sequence against the model on every cycle.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
    localparam int DEF_STAGES = 4;

    // Next-value bundle for the terminal decoder
    typedef struct packed {
        logic carry;
        logic armed;
        logic rst_prev;
    } dec_next_t;
endpackage

// File: rtl/fsr_table.sv
`timescale 1ns/1ps
module fsr_table #(
    parameter int STAGES = fsr_pkg::DEF_STAGES,
    localparam int DEPTH = 1 << STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [STAGES-1:0] waddr,
    input  logic              wbit,
    input  logic [STAGES-1:0] raddr,
    output logic              rbit
);
    typedef struct packed {
        logic [DEPTH-1:0] tbl;
        logic             armed;
    } tbl_next_t;

    tbl_next_t n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (we) begin
            n_d.tbl[waddr] = wbit;
        end
        n_d.armed = n_q.armed | rst;
    end

    // No reset: the contents must outlive reset
    always_ff @(posedge clk) begin
        n_q <= n_d;
    end

    assign rbit = n_q.tbl[raddr];

    // R5
    tbl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (n_q.armed && $past(we)) |-> (n_q.tbl[$past(waddr)] == $past(wbit)));
endmodule

// File: rtl/fsr_shift.sv
`timescale 1ns/1ps
module fsr_shift #(
    parameter int STAGES = fsr_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] seed,
    input  logic              din,
    output logic [STAGES-1:0] state
);
    localparam logic [STAGES-1:0] ALL_ZERO = '0;
    localparam logic [STAGES-1:0] ALL_ONE  = '1;

    typedef struct packed {
        logic [STAGES-1:0] st;
        logic              armed;
        logic              rst_prev;
    } sh_next_t;

    sh_next_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.rst_prev = rst;
        s_d.armed    = s_q.armed | rst;
        if (rst) begin
            s_d.st = seed;
        end else begin
            s_d.st = {s_q.st[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign state = s_q.st;

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.armed && !s_q.rst_prev) |-> (s_q.st[STAGES-1:1] == $past(s_q.st[STAGES-2:0])));

    // R3
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.armed && s_q.rst_prev) |-> (s_q.st == $past(seed)));

    // R8
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.armed && s_q.st == ALL_ZERO && !din) |=> (s_q.st == ALL_ZERO));

    // R8
    ones_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.armed && s_q.st == ALL_ONE && din) |=> (s_q.st == ALL_ONE));
endmodule

// File: rtl/fsr_term.sv
`timescale 1ns/1ps
module fsr_term #(
    parameter int STAGES = fsr_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [STAGES-1:0] wval,
    input  logic [STAGES-1:0] state,
    output logic              carry
);
    import fsr_pkg::*;

    dec_next_t         c_d, c_q;
    logic [STAGES-1:0] term_d, term_q;

    always_comb begin
        term_d = we ? wval : term_q;
        c_d.rst_prev = rst;
        c_d.armed    = c_q.armed | rst;
        c_d.carry    = !rst && (state == term_q);
    end

    // Terminal value has no reset; decoder output does
    always_ff @(posedge clk) begin
        term_q <= term_d;
        c_q    <= c_d;
    end

    assign carry = c_q.carry;

    // R6
    carry_src_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.armed && !c_q.rst_prev && c_q.carry) |-> ($past(state) == $past(term_q)));

    // R3
    carry_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.armed && c_q.rst_prev) |-> !c_q.carry);
endmodule

// File: rtl/fsr_divider.sv
`timescale 1ns/1ps
module fsr_divider #(
    parameter int STAGES = fsr_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] seed,
    input  logic              tbl_we,
    input  logic [STAGES-1:0] tbl_addr,
    input  logic              tbl_bit,
    input  logic              term_we,
    input  logic [STAGES-1:0] term_val,
    output logic [STAGES-1:0] state,
    output logic              carry
);
    logic              fb_bit;
    logic [STAGES-1:0] st;

    fsr_table #(.STAGES(STAGES)) u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr),
        .wbit(tbl_bit), .raddr(st), .rbit(fb_bit)
    );

    fsr_shift #(.STAGES(STAGES)) u_shift (
        .clk(clk), .rst(rst), .seed(seed), .din(fb_bit), .state(st)
    );

    fsr_term #(.STAGES(STAGES)) u_term (
        .clk(clk), .rst(rst), .we(term_we), .wval(term_val),
        .state(st), .carry(carry)
    );

    assign state = st;
endmodule

// File: tb/fsr_divider_test.sv
`timescale 1ns/1ps
module fsr_divider_test;
    localparam int N = 5;
    localparam int D = 1 << N;

    logic clk = 0;
    logic rst = 0;
    logic [N-1:0] seed = '0;
    logic tbl_we = 0;
    logic [N-1:0] tbl_addr = '0;
    logic tbl_bit = 0;
    logic term_we = 0;
    logic [N-1:0] term_val = '0;
    logic [N-1:0] state;
    logic carry;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [D-1:0] mt = '0;
    logic [N-1:0] ms = '0;
    logic [N-1:0] mterm = '0;
    logic mc = 0;

    always #4 clk = ~clk;

    fsr_divider #(.STAGES(N)) uut (
        .clk(clk), .rst(rst), .seed(seed), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_bit(tbl_bit), .term_we(term_we), .term_val(term_val),
        .state(state), .carry(carry)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: model advances from its current view, then state and carry are compared
    task automatic tick(input string tag);
        logic [N-1:0] ns;
        logic nc;
        if (rst) begin
            ns = seed; nc = 0;
        end else begin
            ns = {ms[N-2:0], mt[ms]};
            nc = (ms == mterm);
        end
        if (tbl_we) mt[tbl_addr] = tbl_bit;
        if (term_we) mterm = term_val;
        @(posedge clk);
        @(negedge clk);
        ms = ns; mc = nc;
        tbl_we = 0; term_we = 0;
        chk(state == ms, {tag, " state"}, state, ms);
        chk(carry == mc, {tag, " carry"}, carry, mc);
    endtask

    // Load a full table under reset, then release
    task automatic load_under_reset(input logic [D-1:0] t, input logic [N-1:0] s,
                                    input logic [N-1:0] term);
        rst = 1; seed = s;
        for (int i = 0; i < D; i++) begin
            tbl_we = 1; tbl_addr = N'(i); tbl_bit = t[i];
            if (i == 0) begin term_we = 1; term_val = term; end
            tick("R3 load");
        end
        rst = 0;
    endtask

    function automatic logic [D-1:0] johnson_tbl();
        logic [D-1:0] t;
        for (int i = 0; i < D; i++) t[i] = ~i[N-1];
        return t;
    endfunction

    function automatic logic [D-1:0] mix_tbl(input int k);
        logic [D-1:0] t;
        for (int i = 0; i < D; i++) t[i] = 1'(((i * 13 + k) * 7 >> 3) ^ (i >> 1));
        return t;
    endfunction

    task automatic t_reset();
        rst = 1; seed = 5'd9;
        tick("R3 reset");
        chk(state == 5'd9, "R3 seed", state, 9);
        chk(carry == 0, "R3 carry low", carry, 0);
        rst = 0;
    endtask

    task automatic t_johnson();
        int pulses;
        load_under_reset(johnson_tbl(), 5'd0, 5'd0);
        pulses = 0;
        for (int c = 0; c < 50; c++) begin
            tick("R1 R2 twisted");
            if (carry) pulses++;
        end
        chk(pulses == 5, "R6 period 10", pulses, 5);
    endtask

    task automatic t_mixed();
        load_under_reset(mix_tbl(3), 5'd17, 5'd6);
        for (int c = 0; c < 40; c++) tick("R1 R2 mixed");
    endtask

    task automatic t_retain();
        logic [N-1:0] first;
        rst = 1; seed = 5'd0;
        tick("R4 reset");
        tick("R4 reset");
        rst = 0;
        tick("R4 rerun");
        first = state;
        chk(first == {4'b0, mt[0]}, "R4 table kept", first, {4'b0, mt[0]});
        for (int c = 0; c < 20; c++) tick("R4 rerun");
    endtask

    task automatic t_write_live();
        logic old;
        logic [N-1:0] at;
        load_under_reset(johnson_tbl(), 5'd3, 5'd31);
        for (int c = 0; c < 4; c++) tick("R5 pre");
        at = state; old = mt[at];
        tbl_we = 1; tbl_addr = at; tbl_bit = ~old;
        tick("R5 write edge");
        chk(state[0] == old, "R5 old entry used", state[0], old);
        for (int c = 0; c < 30; c++) tick("R5 after");
    endtask

    task automatic t_term_change();
        load_under_reset(johnson_tbl(), 5'd0, 5'd0);
        for (int c = 0; c < 5; c++) tick("R7 pre");
        term_we = 1; term_val = 5'd28;
        tick("R7 write");
        for (int c = 0; c < 25; c++) tick("R7 after");
    endtask

    task automatic t_fixed();
        load_under_reset('0, 5'd0, 5'd0);
        for (int c = 0; c < 5; c++) tick("R8 zeros");
        chk(state == 5'd0, "R8 zero persists", state, 0);
        chk(carry == 1, "R6 persistent carry", carry, 1);
        load_under_reset('1, 5'd31, 5'd0);
        for (int c = 0; c < 5; c++) tick("R8 ones");
        chk(state == 5'd31, "R8 ones persists", state, 31);
    endtask

    task automatic t_merge();
        logic [D-1:0] t;
        logic [N-1:0] a;
        t = mix_tbl(11);
        for (int i = 0; i < D / 2; i++) t[i + D / 2] = t[i];
        load_under_reset(t, 5'd5, 5'd1);
        tick("R9 from 5");
        a = state;
        rst = 1; seed = 5'd21;
        tick("R9 reseed");
        rst = 0;
        tick("R9 from 21");
        chk(state == a, "R9 merged successor", state, a);
        chk(a == {4'b0101 << 0, t[5]}, "R9 successor value", a, {4'b0101, t[5]});
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_johnson();
        t_mixed();
        t_retain();
        t_write_live();
        t_term_change();
        t_fixed();
        t_merge();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule